// File: doc/BRIEF.md
# CPU-to-PCI I/O Window Decoder

The block holds the three registers that describe one window through which the CPU reaches PCI I/O space: a low decode register, a high decode register and a remap register. Software programs them over a simple 32-bit register bus. From the low and high registers the block works out whether the window is enabled, its base address and its length. Both bounds count in 2 MiB units.

A 36-bit CPU address is compared against the window on every cycle. The block raises a hit flag when the address falls inside an enabled window. The remap value is held and presented to the rest of the host bridge. This block does no translation with it.

Register byte offsets on the bus are 0x0 for the low register, 0x4 for the high register and 0x8 for the remap register. Reads return data one cycle after the request.

Top module: `iowin_decoder`

## Requirements
- R1: A write to offset 0x0 stores bits 14:0 of the written data in the low register and clears its upper bits. The same write loads the remap register with bits 10:0 of the data.
- R2: A write to offset 0x4 stores bits 6:0 of the written data in the high register. Its other bits read as zero.
- R3: A write to offset 0x8 stores bits 10:0 of the data in the remap register. It leaves the low register unchanged. `remap_val` shows the remap register.
- R4: `win_valid` is 1 exactly when bits 6:0 of the low register are less than or equal to the high register. It reflects a register write on the cycle after the register changes.
- R5: While the window is valid, `win_base` equals the full 15-bit low register shifted left by 21. Bits 14:7 of the low register therefore move the base.
- R6: While the window is valid, `win_len` equals (high + 1 - low[6:0]) shifted left by 21. Bits 14:7 of the low register do not affect the length.
- R7: After reset, the registers read low 0x080, high 0x00F and remap 0x080. The window is valid, `win_base` is 0x010000000 and `win_len` is 0x002000000.
- R8: `win_hit` is 1 in the same cycle when the window is valid and base <= `cpu_addr` < base + length. The sum is taken without wrap-around.
- R9: While the window is invalid, `win_hit` is 0. `win_base` and `win_len` keep the values of the last valid configuration.
- R10: A read pulse gives `reg_rvalid` one cycle later, together with the addressed register zero-extended to 32 bits. A read of any other offset returns zero.
- R11: Writes to offsets other than 0x0, 0x4 and 0x8 change no register and no window output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cpu_addr | input | 36 | CPU address to test against the window |
| win_valid | output | 1 | Window enabled |
| win_base | output | 36 | Window base address |
| win_len | output | 36 | Window length in bytes |
| win_hit | output | 1 | cpu_addr lies inside the enabled window |
| remap_val | output | 11 | Stored remap value |

## Verification
A bad masking or decode state would show in two places. Readback of the register concerned would be wrong one cycle after the read. `win_base`, `win_len` or `win_valid` would be wrong one cycle after the write. An off-by-one in the span arithmetic or the bound comparison would appear only at the window edges. For that reason `win_hit` is probed at base - 1, base, base + length - 1 and base + length for every configuration in the sweep. A broken hold would show as a moved base or length after a configuration that makes the window invalid, and it would also show as a hit raised while `win_valid` is 0.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int DW       = 32;
  localparam int AW       = 36;
  localparam int SHIFT    = 21;
  localparam int LOW_W    = 15;
  localparam int HIGH_W   = 7;
  localparam int REMAP_W  = 11;
  localparam int OFS_W    = 4;

  localparam logic [OFS_W-1:0] OFS_LOW   = 4'h0;
  localparam logic [OFS_W-1:0] OFS_HIGH  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_REMAP = 4'h8;

  localparam logic [LOW_W-1:0]   LOW_RST   = 15'h080;
  localparam logic [HIGH_W-1:0]  HIGH_RST  = 7'h0F;
  localparam logic [REMAP_W-1:0] REMAP_RST = 11'h080;
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
#(
  parameter int P_DW = DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                rd,
  input  logic [OFS_W-1:0]    addr,
  input  logic [P_DW-1:0]     wdata,
  output logic [LOW_W-1:0]    low_q,
  output logic [HIGH_W-1:0]   high_q,
  output logic [REMAP_W-1:0]  remap_q,
  output logic [P_DW-1:0]     rdata,
  output logic                rvalid
);
  logic [LOW_W-1:0]   low_d;
  logic [HIGH_W-1:0]  high_d;
  logic [REMAP_W-1:0] remap_d;
  logic [P_DW-1:0]    rdata_d;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[P_DW-1:LOW_W];

  always_comb begin
    low_d   = low_q;
    high_d  = high_q;
    remap_d = remap_q;
    if (wr) begin
      case (addr)
        OFS_LOW: begin
          low_d   = wdata[LOW_W-1:0];
          remap_d = wdata[REMAP_W-1:0];
        end
        OFS_HIGH:  high_d  = wdata[HIGH_W-1:0];
        OFS_REMAP: remap_d = wdata[REMAP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_LOW:   rdata_d = {{(P_DW-LOW_W){1'b0}}, low_q};
      OFS_HIGH:  rdata_d = {{(P_DW-HIGH_W){1'b0}}, high_q};
      OFS_REMAP: rdata_d = {{(P_DW-REMAP_W){1'b0}}, remap_q};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= LOW_RST;
      high_q  <= HIGH_RST;
      remap_q <= REMAP_RST;
    end else if (wr) begin
      low_q   <= low_d;
      high_q  <= high_d;
      remap_q <= remap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/iowin_calc.sv
module iowin_calc
  import iowin_pkg::*;
#(
  parameter int P_AW    = AW,
  parameter int P_SHIFT = SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOW_W-1:0]  low_q,
  input  logic [HIGH_W-1:0] high_q,
  output logic              valid_q,
  output logic [P_AW-1:0]   base_q,
  output logic [P_AW-1:0]   len_q
);
  localparam int SPAN_W = HIGH_W + 1;
  localparam logic [SPAN_W-1:0] RST_SPAN =
    {1'b0, HIGH_RST} + SPAN_W'(1) - {1'b0, LOW_RST[HIGH_W-1:0]};
  localparam logic [P_AW-1:0] RST_BASE = P_AW'(LOW_RST) << P_SHIFT;
  localparam logic [P_AW-1:0] RST_LEN  = P_AW'(RST_SPAN) << P_SHIFT;
  localparam logic RST_VALID = (LOW_RST[HIGH_W-1:0] <= HIGH_RST);

  logic              valid_d;
  logic [SPAN_W-1:0] span;
  logic [P_AW-1:0]   base_d;
  logic [P_AW-1:0]   len_d;

  always_comb begin
    valid_d = (low_q[HIGH_W-1:0] <= high_q);
    span    = {1'b0, high_q} + SPAN_W'(1) - {1'b0, low_q[HIGH_W-1:0]};
    base_d  = P_AW'(low_q) << P_SHIFT;
    len_d   = P_AW'(span) << P_SHIFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= RST_VALID;
      base_q  <= RST_BASE;
      len_q   <= RST_LEN;
    end else begin
      valid_q <= valid_d;
      if (valid_d) begin
        base_q <= base_d;
        len_q  <= len_d;
      end
    end
  end
endmodule

// File: rtl/iowin_hit.sv
module iowin_hit #(
  parameter int P_AW = 36
) (
  input  logic            valid,
  input  logic [P_AW-1:0] base,
  input  logic [P_AW-1:0] len,
  input  logic [P_AW-1:0] addr,
  output logic            hit
);
  logic [P_AW:0] end_x;

  always_comb begin
    end_x = {1'b0, base} + {1'b0, len};
    hit   = valid && (addr >= base) && ({1'b0, addr} < end_x);
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [OFS_W-1:0]    reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                reg_rvalid,
  input  logic [AW-1:0]       cpu_addr,
  output logic                win_valid,
  output logic [AW-1:0]       win_base,
  output logic [AW-1:0]       win_len,
  output logic                win_hit,
  output logic [REMAP_W-1:0]  remap_val
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  iowin_regs #(.P_DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .low_q  (low_q),
    .high_q (high_q),
    .remap_q(remap_val),
    .rdata  (reg_rdata),
    .rvalid (reg_rvalid)
  );

  iowin_calc #(.P_AW(AW), .P_SHIFT(SHIFT)) u_calc (
    .clk    (clk),
    .rst_n  (rst_q),
    .low_q  (low_q),
    .high_q (high_q),
    .valid_q(win_valid),
    .base_q (win_base),
    .len_q  (win_len)
  );

  iowin_hit #(.P_AW(AW)) u_hit (
    .valid(win_valid),
    .base (win_base),
    .len  (win_len),
    .addr (cpu_addr),
    .hit  (win_hit)
  );
endmodule

// File: rtl/iowin_checker.sv
module iowin_checker
  import iowin_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_rvalid,
  input logic [DW-1:0]    reg_rdata,
  input logic [OFS_W-1:0] reg_addr,
  input logic             win_valid,
  input logic             win_hit,
  input logic [AW-1:0]    win_base,
  input logic [AW-1:0]    win_len
);
  localparam logic [AW-1:0] LEN_MAX = AW'(1) << (HIGH_W + SHIFT);

  a_r10_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  a_r1_low_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_LOW) |=> (reg_rdata[DW-1:LOW_W] == '0));

  a_r2_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_HIGH) |=> (reg_rdata[DW-1:HIGH_W] == '0));

  a_r9_no_hit_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> win_valid);

  a_r9_hold_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> ($stable(win_base) && $stable(win_len)));

  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0) && (win_len <= LEN_MAX));

  a_r8_hit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (win_base <= AW'(win_base + win_len - AW'(1)) || (win_base + win_len) == '0));
endmodule

bind iowin_decoder iowin_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .reg_rd    (reg_rd),
  .reg_rvalid(reg_rvalid),
  .reg_rdata (reg_rdata),
  .reg_addr  (reg_addr),
  .win_valid (win_valid),
  .win_hit   (win_hit),
  .win_base  (win_base),
  .win_len   (win_len)
);

// File: tb/sim_iowin_decoder.sv
`timescale 1ns/1ps
module sim_iowin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [35:0] cpu_addr = '0;
  logic        win_valid;
  logic [35:0] win_base;
  logic [35:0] win_len;
  logic        win_hit;
  logic [10:0] remap_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [14:0] m_low;
  logic [6:0]  m_high;
  logic [10:0] m_remap;
  logic        m_valid;
  logic [35:0] m_base;
  logic [35:0] m_len;

  always #2.5 clk = ~clk;

  iowin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .cpu_addr(cpu_addr), .win_valid(win_valid),
    .win_base(win_base), .win_len(win_len), .win_hit(win_hit),
    .remap_val(remap_val)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_calc();
    m_valid = (m_low[6:0] <= m_high);
    if (m_valid) begin
      m_base = 36'(m_low) << 21;
      m_len  = 36'(8'(m_high) + 8'd1 - 8'(m_low[6:0])) << 21;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      4'h0: begin m_low = d[14:0]; m_remap = d[10:0]; end
      4'h4: m_high = d[6:0];
      4'h8: m_remap = d[10:0];
      default: ;
    endcase
    model_calc();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic check_window(input string tag);
    @(negedge clk);
    chk({tag, " R4 valid"}, 64'(win_valid), 64'(m_valid));
    chk({tag, " R5 base"}, 64'(win_base), 64'(m_base));
    chk({tag, " R6 len"}, 64'(win_len), 64'(m_len));
  endtask

  task automatic probe(input logic [36:0] a);
    logic exp;
    if (a[36]) return;
    cpu_addr = a[35:0];
    #1;
    exp = m_valid && ({1'b0, m_base} <= a) && (a < ({1'b0, m_base} + {1'b0, m_len}));
    chk(m_valid ? "R8 hit" : "R9 hit low", 64'(win_hit), 64'(exp));
  endtask

  task automatic edges();
    logic [36:0] b;
    logic [36:0] e;
    b = {1'b0, win_base};
    e = b + {1'b0, win_len};
    if (b != 0) probe(b - 37'd1);
    probe(b);
    probe(e - 37'd1);
    probe(e);
    probe(b + (e - b) / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    m_low = 15'h080; m_high = 7'h0F; m_remap = 11'h080;
    m_valid = 1'b1; m_base = 36'h010000000; m_len = 36'h002000000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    chk("R7 valid", 64'(win_valid), 64'(1));
    chk("R7 base", 64'(win_base), 64'h010000000);
    chk("R7 len", 64'(win_len), 64'h002000000);
    chk("R7 remap", 64'(remap_val), 64'h080);
    rd(4'h0, d, v); chk("R7 low rd", 64'(d), 64'h080); chk("R10 rvalid", 64'(v), 64'(1));
    rd(4'h4, d, v); chk("R7 high rd", 64'(d), 64'h00F);
    rd(4'h8, d, v); chk("R7 remap rd", 64'(d), 64'h080);
    rd(4'hC, d, v); chk("R10 unmapped rd", 64'(d), 64'h0);
    edges();

    // R1 low write mask and remap load
    wr(4'h0, 32'hFFFF_ABCD);
    rd(4'h0, d, v); chk("R1 low mask", 64'(d), 64'(32'h2BCD));
    rd(4'h8, d, v); chk("R1 remap load", 64'(d), 64'(32'h3CD));
    chk("R3 remap_val", 64'(remap_val), 64'(m_remap));
    // R2 high write mask
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d, v); chk("R2 high mask", 64'(d), 64'h7F);
    // R3 remap direct write leaves low alone
    wr(4'h8, 32'h1234_5FFF);
    rd(4'h8, d, v); chk("R3 remap mask", 64'(d), 64'h7FF);
    rd(4'h0, d, v); chk("R3 low kept", 64'(d), 64'(m_low));
    check_window("basic");

    // R11 unmapped writes ignored
    wr(4'hC, 32'h0000_0000);
    wr(4'h2, 32'h0000_0000);
    check_window("R11");
    rd(4'h0, d, v); chk("R11 low", 64'(d), 64'(m_low));
    rd(4'h4, d, v); chk("R11 high", 64'(d), 64'(m_high));
    rd(4'h8, d, v); chk("R11 remap", 64'(d), 64'(m_remap));

    // R4/R5/R6/R8/R9 sweep
    for (int lo = 0; lo < 128; lo += 9) begin
      for (int hi = 0; hi < 128; hi += 11) begin
        logic [7:0] up;
        up = 8'(lo * 37 + hi * 13);
        wr(4'h0, {9'h1AB, up, 7'(lo)});
        wr(4'h4, 32'(hi) | 32'hFF00);
        check_window("sweep");
        edges();
      end
    end

    // R9 explicit hold after going invalid
    wr(4'h0, 32'h0000_0005);
    wr(4'h4, 32'h0000_0009);
    check_window("pre-hold");
    wr(4'h4, 32'h0000_0002);
    check_window("R9 hold");
    chk("R9 invalid", 64'(win_valid), 64'(0));
    edges();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule